// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block sits beside the receive path of an I2C target and decides which bus speed class is in force. It watches SCL and SDA, oversampled on a fast system clock, and finds START, repeated START and STOP conditions. It shifts in the first byte after every START and checks whether that byte is the high-speed master code.

When the master code arrives, the block raises a hold-off signal for the ACK clock so the acknowledge logic leaves SDA released. At the end of that clock it switches a mode output that selects the high-speed input filter and timing limits. The mode stays set across any number of repeated STARTs and falls back to standard/fast only on a STOP.

Any other first byte is handed on unchanged with a one-cycle valid strobe for address matching elsewhere. Address matching, register access and driving SDA are not part of this block.

Top module: `hs_mode_detector`

## Requirements
- R1: After reset `hs_mode`, `ack_inhibit`, `byte_valid`, `bus_start` and `bus_stop` are all 0, and a reset while in high-speed mode returns `hs_mode` to 0.
- R2: SDA falling while SCL is high (START or repeated START) gives a one-cycle pulse on `bus_start`; SDA changes while SCL is low give no pulse.
- R3: SDA rising while SCL is high (STOP) gives a one-cycle pulse on `bus_stop`.
- R4: Only the first byte after each START is captured, MSB first, on SCL rising edges; later bytes in the same transfer produce no strobe and no mode change.
- R5: A first byte that is not the master code is presented on `byte_data` with a one-cycle `byte_valid` pulse, and `hs_mode` is unchanged.
- R6: A first byte whose upper five bits are 00001 is the master code whatever its low three bits are; it produces no `byte_valid` pulse.
- R7: For a master code, `ack_inhibit` is 1 from the eighth SCL rising edge to the falling edge of the ninth SCL clock and is 0 otherwise.
- R8: `hs_mode` keeps its previous value while the master code and its ACK clock are received, and becomes 1 at the falling edge of that ninth clock.
- R9: `hs_mode` stays 1 through repeated STARTs and the transfers that follow them.
- R10: A STOP clears `hs_mode`; a STOP in standard/fast mode changes nothing else; a STOP in the middle of a byte discards it, and capture restarts cleanly at the next START.
- R11: With `SYNC_STAGES` = 2, `bus_start` rises on the third clock edge after SDA falls while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| bus_start | output | 1 | One-cycle pulse on START or repeated START |
| bus_stop | output | 1 | One-cycle pulse on STOP |
| byte_data | output | 8 | Last first-byte that was not the master code |
| byte_valid | output | 1 | One-cycle strobe when `byte_data` is updated |
| ack_inhibit | output | 1 | Keep SDA released during the master code ACK clock |
| hs_mode | output | 1 | 1 selects the high-speed filter and timing, 0 standard/fast |

## Verification
A wrong bit counter or capture state shows at the ports within one byte time. Either the strobe and `byte_data` disagree with the byte sent, or `ack_inhibit` is missing or mistimed in the ninth clock. A wrong mode register shows at the first STOP, repeated START or reset after the fault, because `hs_mode` is sampled after each ACK clock and after each STOP. Condition-detection faults show within three system clocks as a missing, extra or late start or stop pulse.

// File: rtl/hs_det_pkg.sv
// Package: shared types and constants for the high-speed mode entry detector.
// Assumes: SCL is line index 0 and SDA is line index 1 in the synchroniser.
package hs_det_pkg;

    localparam int SCL_IDX  = 0;
    localparam int SDA_IDX  = 1;
    localparam int LINE_CNT = 2;

    // State of the first-byte capture engine
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,   // waiting for a START
        CAP_SHIFT = 2'd1,   // shifting in the first byte
        CAP_ACK   = 2'd2    // master code ACK clock in progress
    } cap_state_e;

endpackage

// File: rtl/bus_line_sync.sv
// Module: bus_line_sync
// Brings each raw bus line through a chain of STAGES flops and keeps one
// more flop of history for edge detection.
// Assumes: lines idle high, so every flop resets to 1.
module bus_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev_q;

        // Shift the line through the synchroniser and keep one older sample
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain  <= '1;
                prev_q <= 1'b1;
            end else begin
                chain  <= (chain << 1) | STAGES'(lines_in[g]);
                prev_q <= chain[STAGES-1];
            end
        end

        assign cur[g]  = chain[STAGES-1];
        assign prev[g] = prev_q;
    end

endmodule

// File: rtl/bus_cond_detect.sv
// Module: bus_cond_detect
// Finds START/STOP conditions and SCL edges from current and previous line
// samples, and registers the condition pulses for the outside world.
// Assumes: inputs are already synchronised to clk.
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_pulse,
    output logic stop_pulse
);

    logic scl_steady_high;

    // Decode conditions and clock edges from the two samples
    always_comb begin
        scl_steady_high = scl_cur & scl_prev;
        start_det       = scl_steady_high & sda_prev & ~sda_cur;
        stop_det        = scl_steady_high & ~sda_prev & sda_cur;
        scl_rise        = scl_cur & ~scl_prev;
        scl_fall        = ~scl_cur & scl_prev;
    end

    // Register the condition pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            start_pulse <= start_det;
            stop_pulse  <= stop_det;
        end
    end

endmodule

// File: rtl/first_byte_capture.sv
// Module: first_byte_capture
// Shifts in the first byte after each START, MSB first on SCL rising
// edges. An ordinary byte is passed out with a strobe; a master code holds
// off the acknowledge for the ninth clock and reports the end of that clock.
// Assumes: START and STOP never coincide with an SCL edge.
module first_byte_capture
    import hs_det_pkg::*;
#(
    parameter int                   BYTE_W      = 8,
    parameter int                   MC_PREFIX_W = 5,
    parameter logic [MC_PREFIX_W-1:0] MC_PREFIX = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              ack_inhibit,
    output logic              mc_ack_end
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    cap_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shift_q;
    logic              fall_seen;
    logic [BYTE_W-1:0] next_byte;
    logic              last_bit;
    logic              is_mc;

    // Form the byte as it will be after this bit and test for the master code
    always_comb begin
        next_byte  = {shift_q[BYTE_W-2:0], sda_bit};
        last_bit   = (bit_cnt == CNT_W'(BYTE_W - 1));
        is_mc      = (next_byte[BYTE_W-1 -: MC_PREFIX_W] == MC_PREFIX);
        mc_ack_end = (state == CAP_ACK) && scl_fall && fall_seen;
    end

    // Capture sequencing: shift, classify, then track the ACK clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= CAP_IDLE;
            bit_cnt     <= '0;
            shift_q     <= '0;
            byte_data   <= '0;
            byte_valid  <= 1'b0;
            ack_inhibit <= 1'b0;
            fall_seen   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (start_det) begin
                state       <= CAP_SHIFT;
                bit_cnt     <= '0;
                ack_inhibit <= 1'b0;
                fall_seen   <= 1'b0;
            end else if (stop_det) begin
                state       <= CAP_IDLE;
                ack_inhibit <= 1'b0;
                fall_seen   <= 1'b0;
            end else begin
                case (state)
                    CAP_SHIFT: begin
                        if (scl_rise) begin
                            shift_q <= next_byte;
                            if (last_bit) begin
                                if (is_mc) begin
                                    state       <= CAP_ACK;
                                    ack_inhibit <= 1'b1;
                                    fall_seen   <= 1'b0;
                                end else begin
                                    state      <= CAP_IDLE;
                                    byte_data  <= next_byte;
                                    byte_valid <= 1'b1;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    CAP_ACK: begin
                        if (scl_fall) begin
                            if (fall_seen) begin
                                state       <= CAP_IDLE;
                                ack_inhibit <= 1'b0;
                            end else begin
                                fall_seen <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/hs_mode_ctrl.sv
// Module: hs_mode_ctrl
// Holds the speed-class flag: set when a master code ACK clock ends,
// cleared by STOP, untouched by repeated START.
// Assumes: set and clear requests never arrive in the same cycle.
module hs_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_det,
    input  logic mc_ack_end,
    output logic hs_mode
);

    // Update the speed-class flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_mode <= 1'b0;
        end else if (stop_det) begin
            hs_mode <= 1'b0;
        end else if (mc_ack_end) begin
            hs_mode <= 1'b1;
        end
    end

endmodule

// File: rtl/hs_mode_detector.sv
// Module: hs_mode_detector (top)
// Tracks whether the I2C bus runs at standard/fast or high speed for a
// target device, and hands ordinary first bytes to address matching.
// Assumes: clk is fast enough to see every SCL phase over SYNC_STAGES+1 cycles.
module hs_mode_detector
    import hs_det_pkg::*;
#(
    parameter int                     SYNC_STAGES = 2,
    parameter int                     BYTE_W      = 8,
    parameter int                     MC_PREFIX_W = 5,
    parameter logic [MC_PREFIX_W-1:0] MC_PREFIX   = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              bus_start,
    output logic              bus_stop,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              ack_inhibit,
    output logic              hs_mode
);

    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] line_cur;
    logic [LINE_CNT-1:0] line_prev;
    logic start_det, stop_det, scl_rise, scl_fall, mc_ack_end;

    assign raw_lines[SCL_IDX] = scl_in;
    assign raw_lines[SDA_IDX] = sda_in;

    bus_line_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINE_CNT)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (raw_lines),
        .cur      (line_cur),
        .prev     (line_prev)
    );

    bus_cond_detect i_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_cur     (line_cur[SCL_IDX]),
        .scl_prev    (line_prev[SCL_IDX]),
        .sda_cur     (line_cur[SDA_IDX]),
        .sda_prev    (line_prev[SDA_IDX]),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_pulse (bus_start),
        .stop_pulse  (bus_stop)
    );

    first_byte_capture #(
        .BYTE_W      (BYTE_W),
        .MC_PREFIX_W (MC_PREFIX_W),
        .MC_PREFIX   (MC_PREFIX)
    ) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_bit     (line_cur[SDA_IDX]),
        .byte_data   (byte_data),
        .byte_valid  (byte_valid),
        .ack_inhibit (ack_inhibit),
        .mc_ack_end  (mc_ack_end)
    );

    hs_mode_ctrl i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_det   (stop_det),
        .mc_ack_end (mc_ack_end),
        .hs_mode    (hs_mode)
    );

endmodule

// File: rtl/hs_mode_detector_chk.sv
// Module: hs_mode_detector_chk
// Port-level properties of the detector, bound to every instance.
module hs_mode_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_start,
    input logic bus_stop,
    input logic byte_valid,
    input logic ack_inhibit,
    input logic hs_mode
);

    // R2
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    // R3
    start_stop_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_start && bus_stop));

    // R10
    stop_leaves_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |-> !hs_mode);

    // R10
    hs_exit_by_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode) |-> bus_stop);

    // R8
    hs_entry_at_ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ($past(ack_inhibit) && !ack_inhibit));

    // R9
    hs_kept_over_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && hs_mode) |=> hs_mode);

    // R6
    no_strobe_when_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !ack_inhibit);

endmodule

bind hs_mode_detector hs_mode_detector_chk i_chk (.*);

// File: tb/test_hs_mode_detector.sv
// Bench: walks a vector table of first bytes, then directed corner cases.
module test_hs_mode_detector;

    localparam int H = 6;        // system clocks per bus phase
    localparam int NVEC = 10;
    // {stop_after, byte}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 8'h50}, {1'b0, 8'h08}, {1'b0, 8'h50}, {1'b1, 8'hA3},
        {1'b0, 8'h0F}, {1'b0, 8'h3C}, {1'b1, 8'h0B}, {1'b0, 8'h07},
        {1'b1, 8'h18}, {1'b1, 8'h09}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       bus_start, bus_stop, byte_valid, ack_inhibit, hs_mode;
    logic [7:0] byte_data;

    int n_tests = 0;
    int n_fail = 0;
    int n_start = 0;
    int n_stop = 0;
    int n_valid = 0;
    int last_byte = 0;
    int exp_start = 0;
    int exp_stop = 0;
    int exp_valid = 0;
    logic hs_exp = 1'b0;

    always #4 clk = ~clk;

    hs_mode_detector i_hs_mode_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl),
        .sda_in      (sda),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .byte_data   (byte_data),
        .byte_valid  (byte_valid),
        .ack_inhibit (ack_inhibit),
        .hs_mode     (hs_mode)
    );

    // Count output pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_start) n_start++;
            if (bus_stop) n_stop++;
            if (byte_valid) begin
                n_valid++;
                last_byte = int'(byte_data);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic do_start();
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        sda = 1'b0; hold();
        scl = 1'b0; hold();
        exp_start++;
    endtask

    task automatic do_stop();
        scl = 1'b0; hold();
        sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
        exp_stop++;
    endtask

    task automatic send_bit(input logic b);
        sda = b;    hold();
        scl = 1'b1; hold();
        scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Ninth clock with SDA released; checks inhibit, strobe and mode
    task automatic ack_clock(input logic [7:0] b, input logic first);
        logic mc;
        mc = first && (b[7:3] == 5'b00001);
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        chk("R7", "ack_inhibit in ninth clock", int'(ack_inhibit), int'(mc));
        chk("R8", "hs_mode during ACK clock", int'(hs_mode), int'(hs_exp));
        if (first && !mc) begin
            exp_valid++;
            chk("R5", "byte_valid count", n_valid, exp_valid);
            chk("R4", "byte_data", last_byte, int'(b));
        end else begin
            chk("R6", "no strobe for master code or later byte", n_valid, exp_valid);
        end
        scl = 1'b0; hold();
        if (mc) hs_exp = 1'b1;
        chk("R7", "ack_inhibit after ninth clock", int'(ack_inhibit), 0);
        chk("R9", "hs_mode after ACK clock", int'(hs_mode), int'(hs_exp));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: got %0d cycles expected fewer", 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hold();
        // R1 reset state
        chk("R1", "hs_mode after reset", int'(hs_mode), 0);
        chk("R1", "ack_inhibit after reset", int'(ack_inhibit), 0);
        chk("R1", "byte_valid after reset", int'(byte_valid), 0);
        chk("R1", "pulses after reset", n_start + n_stop, 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            do_start();
            chk("R2", "start count", n_start, exp_start);
            send_byte(VEC[v][7:0]);
            chk("R2", "no start from data bits", n_start, exp_start);
            ack_clock(VEC[v][7:0], 1'b1);
            if (VEC[v][8]) begin
                do_stop();
                hs_exp = 1'b0;
                chk("R3", "stop count", n_stop, exp_stop);
                chk("R10", "hs_mode after STOP", int'(hs_mode), 0);
            end
        end

        // R10 STOP in standard/fast mode is harmless
        do_stop();
        chk("R3", "stop count idle", n_stop, exp_stop);
        chk("R10", "hs_mode after idle STOP", int'(hs_mode), 0);
        chk("R10", "no strobe from idle STOP", n_valid, exp_valid);

        // R10 STOP mid master code discards the partial byte
        do_start();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        do_stop();
        chk("R10", "hs_mode after aborted code", int'(hs_mode), 0);
        do_start();
        send_byte(8'h50);
        ack_clock(8'h50, 1'b1);
        chk("R10", "capture restarts after abort", last_byte, 32'h50);

        // R4 a second byte that looks like a master code is ignored
        send_byte(8'h08);
        ack_clock(8'h08, 1'b0);
        chk("R4", "second byte leaves mode", int'(hs_mode), 0);
        do_stop();

        // R11 latency of the START pulse
        @(negedge clk);
        sda = 1'b0;
        exp_start++;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "bus_start two clocks after fall", int'(bus_start), 0);
        @(negedge clk);
        chk("R11", "bus_start three clocks after fall", int'(bus_start), 1);
        hold();
        scl = 1'b0; hold();
        do_stop();
        chk("R2", "start count after latency test", n_start, exp_start);

        // R1 reset while in high-speed mode
        do_start();
        send_byte(8'h0A);
        ack_clock(8'h0A, 1'b1);
        chk("R9", "hs_mode set before reset", int'(hs_mode), 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "hs_mode cleared by reset", int'(hs_mode), 0);
        chk("R1", "ack_inhibit cleared by reset", int'(ack_inhibit), 0);
        rst_n = 1'b1;
        hs_exp = 1'b0;
        hold();
        do_stop();
        chk("R3", "stop count after reset", n_stop, exp_stop);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule